// File: doc/BRIEF.md
# Operand-tracking ALU issue controller

This block sits in front of a small integer ALU and supervises one operation from the moment it is accepted until its result has been stored. An issue strobe delivers an operation record (opcode, operand-A inversion, operand-A zeroing, an immediate value and its valid flag). From the cycle after acceptance the block reports busy, and raises a read request on every source port whose operand it actually needs. A one-cycle go pulse on a port grants that request and the operand on that port's data lane is taken in the same cycle.

Once every needed operand is held, the ALU result is registered and a write request is raised with the result on the data output. The result is never discarded: busy stays high until a write go pulse confirms storage, and only then can another operation be accepted. Ports may be granted in any order, after any number of stall cycles, or all in the same cycle.

Top module: `alu_issue_ctrl`

## Requirements
- R1: `busy_o` is low after reset and never rises unless `issue_i` was high in the previous cycle while `busy_o` was low; it is then high from the next cycle, and `issue_i` seen while `busy_o` is high is ignored.
- R2: The operation record is sampled only in the accepting issue cycle; changing the record inputs afterwards has no effect on the result.
- R3: For each needed port, `rd_rel_o[i]` rises in the cycle after acceptance and stays high for any number of cycles until `rd_go_i[i]` is seen high.
- R4: `rd_rel_o[i]` falls in the cycle after a cycle in which `rd_rel_o[i]` and `rd_go_i[i]` are both high, and the lane `src_i[i*W +: W]` is sampled in that go cycle; a go on a port whose request is low is ignored.
- R5: With `op_zero_a_i` set, no request is raised on port 0 and operand A is 0.
- R6: With `op_imm_ok_i` set, no request is raised on port 1 and operand B is `op_imm_i`.
- R7: Opcode 1 (add) yields (A' + B + C) mod 2^W, where A' is A bitwise inverted when `op_inv_a_i` is set and C is the port-2 operand (0 when only two ports exist); opcodes 0, 2 and 3 pass operand A through unchanged (no inversion).
- R8: `wr_rel_o` rises with the result on `data_o` two cycles after the cycle of the last read grant, or two cycles after acceptance when no port needs a read; no read request is high while `wr_rel_o` is high.
- R9: `wr_rel_o` and `data_o` hold until `wr_go_i` is high; in the next cycle `wr_rel_o` and `busy_o` are low, and `busy_o` is high throughout from acceptance to that point.
- R10: Synchronous reset `rst` clears `busy_o`, all requests, `data_o` and the latched operands, including in the middle of an operation.
- R11: When three ports are configured, port 2 is always requested and handled exactly like ports 0 and 1 using bit 2 of `rd_rel_o` and `rd_go_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue strobe, accepted while idle |
| op_code_i | input | 2 | Opcode: 0 pass A, 1 add, 2-3 pass A |
| op_inv_a_i | input | 1 | Invert operand A before the add |
| op_zero_a_i | input | 1 | Operand A is zero, no port-0 read |
| op_imm_i | input | W | Immediate value for operand B |
| op_imm_ok_i | input | 1 | Immediate replaces operand B, no port-1 read |
| src_i | input | NSRC*W | Operand lanes, port i at bits i*W +: W |
| rd_rel_o | output | NSRC | Per-port read request |
| rd_go_i | input | NSRC | Per-port read grant pulse |
| wr_rel_o | output | 1 | Result ready, write request |
| wr_go_i | input | 1 | Write grant pulse, releases the unit |
| busy_o | output | 1 | Operation in progress |
| data_o | output | W | Registered ALU result |

## Verification
Two events that may coincide are read grants on several ports, and a grant arriving in the very cycle its request first shows. The bench provokes both by answering all three ports with zero delay right after issue, and contrasts this with staggered grants where one port is stalled several cycles while another is granted early. A behavioural model, updated on every clock from the same inputs, predicts requests, busy, write request and data each cycle, so a grant lost in a coinciding cycle shows up as a request that stays high or a wrong sum.

// File: rtl/alu_issue_pkg.sv
package alu_issue_pkg;
  typedef enum logic [1:0] {
    AIC_IDLE  = 2'd0,
    AIC_READ  = 2'd1,
    AIC_WRITE = 2'd2
  } aic_state_t;

  localparam logic [1:0] AIC_OP_PASS = 2'd0;
  localparam logic [1:0] AIC_OP_ADD  = 2'd1;

  typedef struct packed {
    logic [1:0] code;
    logic       inv_a;
    logic       zero_a;
    logic       imm_ok;
  } aic_ctl_t;
endpackage

// File: rtl/aic_op_latch.sv
module aic_op_latch #(
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  alu_issue_pkg::aic_ctl_t   ctl_in,
  input  logic [W-1:0]              imm_in,
  output alu_issue_pkg::aic_ctl_t   ctl_q,
  output logic [W-1:0]              imm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      imm_q <= '0;
    end else if (load) begin
      ctl_q <= ctl_in;
      imm_q <= imm_in;
    end
  end
endmodule

// File: rtl/aic_src_port.sv
module aic_src_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_set,
  input  logic         go,
  input  logic [W-1:0] src,
  output logic         rel,
  output logic         grant,
  output logic [W-1:0] opnd
);
  assign grant = rel && go;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel  <= 1'b0;
      opnd <= '0;
    end else begin
      if (req_set)    rel <= 1'b1;
      else if (grant) rel <= 1'b0;
      if (grant)      opnd <= src;
    end
  end
endmodule

// File: rtl/aic_alu.sv
module aic_alu #(
  parameter int W = 16
) (
  input  logic [1:0]   code,
  input  logic         inv_a,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  function automatic logic [W-1:0] alu_eval(input logic [1:0] op, input logic inv,
                                            input logic [W-1:0] x, input logic [W-1:0] p,
                                            input logic [W-1:0] q);
    logic [W-1:0] xa;
    xa = inv ? ~x : x;
    if (op == alu_issue_pkg::AIC_OP_ADD) return xa + p + q;
    return x;
  endfunction

  assign y = alu_eval(code, inv_a, a, b, c);
endmodule

// File: rtl/alu_issue_ctrl.sv
module alu_issue_ctrl #(
  parameter int W    = 16,
  parameter int NSRC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [1:0]        op_code_i,
  input  logic              op_inv_a_i,
  input  logic              op_zero_a_i,
  input  logic [W-1:0]      op_imm_i,
  input  logic              op_imm_ok_i,
  input  logic [NSRC*W-1:0] src_i,
  output logic [NSRC-1:0]   rd_rel_o,
  input  logic [NSRC-1:0]   rd_go_i,
  output logic              wr_rel_o,
  input  logic              wr_go_i,
  output logic              busy_o,
  output logic [W-1:0]      data_o
);
  import alu_issue_pkg::*;

  aic_state_t     st;
  aic_ctl_t       ctl_in, ctl_q;
  logic [W-1:0]   imm_q;
  logic [NSRC-1:0] need, grant;
  logic [W-1:0]   opnd [NSRC];
  logic [W-1:0]   alu_a, alu_b, alu_c, alu_y;

  // named events for the checker
  logic accept, operands_done, release_ev;

  assign accept        = issue_i && (st == AIC_IDLE);
  assign operands_done = (st == AIC_READ) && (rd_rel_o == '0);
  assign release_ev    = (st == AIC_WRITE) && wr_go_i;

  assign ctl_in = '{code: op_code_i, inv_a: op_inv_a_i,
                    zero_a: op_zero_a_i, imm_ok: op_imm_ok_i};

  aic_op_latch #(.W(W)) op_latch_i (
    .clk(clk), .rst(rst), .load(accept),
    .ctl_in(ctl_in), .imm_in(op_imm_i),
    .ctl_q(ctl_q), .imm_q(imm_q)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_port
    if (i == 0) begin : g_a
      assign need[i] = !op_zero_a_i;
    end else if (i == 1) begin : g_b
      assign need[i] = !op_imm_ok_i;
    end else begin : g_x
      assign need[i] = 1'b1;
    end
    aic_src_port #(.W(W)) port_i (
      .clk(clk), .rst(rst),
      .req_set(accept && need[i]),
      .go(rd_go_i[i]),
      .src(src_i[i*W +: W]),
      .rel(rd_rel_o[i]),
      .grant(grant[i]),
      .opnd(opnd[i])
    );
  end

  assign alu_a = ctl_q.zero_a ? '0 : opnd[0];
  assign alu_b = ctl_q.imm_ok ? imm_q : opnd[1];
  if (NSRC > 2) begin : g_c
    assign alu_c = opnd[2];
  end else begin : g_noc
    assign alu_c = '0;
  end

  aic_alu #(.W(W)) alu_i (
    .code(ctl_q.code), .inv_a(ctl_q.inv_a),
    .a(alu_a), .b(alu_b), .c(alu_c), .y(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= AIC_IDLE;
      data_o <= '0;
    end else begin
      case (st)
        AIC_IDLE:  if (accept)        st <= AIC_READ;
        AIC_READ:  if (operands_done) st <= AIC_WRITE;
        AIC_WRITE: if (release_ev)    st <= AIC_IDLE;
        default:                      st <= AIC_IDLE;
      endcase
      if (operands_done) data_o <= alu_y;
    end
  end

  assign busy_o   = (st != AIC_IDLE);
  assign wr_rel_o = (st == AIC_WRITE);
endmodule

// File: rtl/aic_checker.sv
module aic_checker #(
  parameter int W    = 16,
  parameter int NSRC = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_i,
  input logic            op_zero_a_i,
  input logic            op_imm_ok_i,
  input logic            busy_o,
  input logic [NSRC-1:0] rd_rel_o,
  input logic [NSRC-1:0] rd_go_i,
  input logic            wr_rel_o,
  input logic            wr_go_i,
  input logic [W-1:0]    data_o,
  input logic            accept,
  input logic            operands_done,
  input logic            release_ev
);
  a_r1_no_self_rise: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !issue_i) |=> !busy_o);
  a_r1_rise_after_issue: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_o);
  a_r5_no_port0_req: assert property (@(posedge clk) disable iff (rst)
    (accept && op_zero_a_i) |=> !rd_rel_o[0]);
  a_r6_no_port1_req: assert property (@(posedge clk) disable iff (rst)
    (accept && op_imm_ok_i) |=> !rd_rel_o[1]);
  a_r8_write_follows: assert property (@(posedge clk) disable iff (rst)
    operands_done |=> wr_rel_o);
  a_r8_no_read_in_write: assert property (@(posedge clk) disable iff (rst)
    wr_rel_o |-> (rd_rel_o == '0) && busy_o);
  a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
    (wr_rel_o && !wr_go_i) |=> wr_rel_o && $stable(data_o));
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    release_ev |=> !busy_o && !wr_rel_o);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r3_rel_holds: assert property (@(posedge clk) disable iff (rst)
      (rd_rel_o[i] && !rd_go_i[i]) |=> rd_rel_o[i]);
    a_r4_rel_drops: assert property (@(posedge clk) disable iff (rst)
      (rd_rel_o[i] && rd_go_i[i]) |=> !rd_rel_o[i]);
  end
endmodule

bind alu_issue_ctrl aic_checker #(.W(W), .NSRC(NSRC)) chk_i (
  .clk(clk), .rst(rst), .issue_i(issue_i),
  .op_zero_a_i(op_zero_a_i), .op_imm_ok_i(op_imm_ok_i),
  .busy_o(busy_o), .rd_rel_o(rd_rel_o), .rd_go_i(rd_go_i),
  .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i), .data_o(data_o),
  .accept(accept), .operands_done(operands_done), .release_ev(release_ev)
);

// File: tb/alu_issue_ctrl_tb_top.sv
`timescale 1ns/1ps
module alu_issue_ctrl_tb_top;
  localparam int W = 16;
  localparam int NSRC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_i = 1'b0;
  logic [1:0] op_code_i = '0;
  logic op_inv_a_i = 1'b0, op_zero_a_i = 1'b0, op_imm_ok_i = 1'b0;
  logic [W-1:0] op_imm_i = '0;
  logic [NSRC*W-1:0] src_i = '0;
  logic [NSRC-1:0] rd_go_i = '0;
  logic wr_go_i = 1'b0;
  logic [NSRC-1:0] rd_rel_o;
  logic wr_rel_o, busy_o;
  logic [W-1:0] data_o;

  always #2.5 clk = ~clk;

  alu_issue_ctrl #(.W(W), .NSRC(NSRC)) dut_i (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_code_i(op_code_i),
    .op_inv_a_i(op_inv_a_i), .op_zero_a_i(op_zero_a_i), .op_imm_i(op_imm_i),
    .op_imm_ok_i(op_imm_ok_i), .src_i(src_i), .rd_rel_o(rd_rel_o),
    .rd_go_i(rd_go_i), .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i),
    .busy_o(busy_o), .data_o(data_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every clock
  int m_phase = 0;            // 0 idle, 1 reading, 2 writing
  bit [2:0] m_req = '0;
  int m_opnd[3] = '{0, 0, 0};
  int m_code = 0, m_inv = 0, m_zero = 0, m_immok = 0, m_imm = 0;
  int m_data = 0;
  bit armed = 0;

  function automatic int ref_result();
    int a, b, s;
    a = m_zero ? 0 : m_opnd[0];
    b = m_immok ? m_imm : m_opnd[1];
    if (m_code == 1) begin
      s = m_inv ? (a ^ 'hFFFF) : a;
      return (s + b + m_opnd[2]) % 65536;
    end
    return a;
  endfunction

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      m_phase = 0; m_req = '0; m_data = 0; m_opnd = '{0, 0, 0};
      m_code = 0; m_inv = 0; m_zero = 0; m_immok = 0; m_imm = 0;
    end else if (m_phase == 0) begin
      if (issue_i) begin
        m_code = int'(op_code_i); m_inv = int'(op_inv_a_i);
        m_zero = int'(op_zero_a_i); m_immok = int'(op_imm_ok_i);
        m_imm = int'(op_imm_i);
        m_req = {1'b1, !op_imm_ok_i, !op_zero_a_i};
        m_phase = 1;
      end
    end else if (m_phase == 1) begin
      if (m_req == 0) begin
        m_data = ref_result();
        m_phase = 2;
      end else begin
        for (int i = 0; i < 3; i++)
          if (m_req[i] && rd_go_i[i]) begin
            m_opnd[i] = int'(src_i[i*W +: W]);
            m_req[i] = 1'b0;
          end
      end
    end else begin
      if (wr_go_i) m_phase = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      check(busy_o == (m_phase != 0), "R1/R9 busy", int'(busy_o), int'(m_phase != 0));
      check(rd_rel_o == m_req, "R3/R4/R11 rd_rel", int'(rd_rel_o), int'(m_req));
      check(wr_rel_o == (m_phase == 2), "R8/R9 wr_rel", int'(wr_rel_o), int'(m_phase == 2));
      check(int'(data_o) == m_data, "R7/R10 data", int'(data_o), m_data);
    end
  end

  task automatic run_op(input int code, input int inv, input int zero, input int imm,
                        input int immok, input int a, input int b, input int c,
                        input int d0, input int d1, input int d2, input int wd,
                        input bit hold_issue, input bit stray, input int exp,
                        input string tag);
    int cnt[3];
    int dly[3];
    int val[3];
    int wc;
    bit seen;
    cnt = '{0, 0, 0}; dly = '{d0, d1, d2}; val = '{a, b, c};
    wc = 0; seen = 0;
    @(negedge clk);
    issue_i = 1'b1; op_code_i = 2'(code); op_inv_a_i = 1'(inv);
    op_zero_a_i = 1'(zero); op_imm_i = 16'(imm); op_imm_ok_i = 1'(immok);
    src_i = {16'hDEAD, 16'hBEEF, 16'hCAFE};
    @(negedge clk);
    issue_i = hold_issue;        // R1: issue while busy must be ignored
    op_code_i = ~op_code_i; op_inv_a_i = ~op_inv_a_i;   // R2: scrambled record
    op_zero_a_i = ~op_zero_a_i; op_imm_ok_i = ~op_imm_ok_i; op_imm_i = ~op_imm_i;
    for (int k = 0; k < 80; k++) begin
      rd_go_i = '0; wr_go_i = 1'b0;
      src_i = {16'h1357, 16'h2468, 16'h0F0F};
      if (k >= 2) issue_i = 1'b0;
      if (!busy_o) break;
      if (stray && k == 0) rd_go_i[0] = 1'b1;   // R4: go with no request
      for (int i = 0; i < 3; i++)
        if (rd_rel_o[i]) begin
          if (cnt[i] >= dly[i]) begin
            rd_go_i[i] = 1'b1;
            src_i[i*W +: W] = 16'(val[i]);
          end else cnt[i]++;
        end
      if (wr_rel_o) begin
        if (!seen) check(int'(data_o) == exp, tag, int'(data_o), exp);
        seen = 1;
        if (wc >= wd) wr_go_i = 1'b1; else wc++;
      end
      @(negedge clk);
    end
    issue_i = 1'b0;
    check(seen && !busy_o, {tag, " R9 completed"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(!busy_o && rd_rel_o == 0 && !wr_rel_o && data_o == 0, "R10 reset state",
          int'(busy_o), 0);
    // R7 pass-through: 5,2 -> 5
    run_op(0, 0, 0, 0, 0, 5, 2, 0, 0, 0, 0, 0, 0, 0, 5, "R7 pass A");
    // R7 inverted add: ~5 + 2 -> 65532
    run_op(1, 1, 0, 0, 0, 5, 2, 0, 0, 0, 0, 1, 0, 0, 65532, "R7 inverted add");
    // R1 R2 R3 staggered grants with stalls, issue held while busy
    run_op(1, 0, 0, 0, 0, 100, 200, 7, 0, 3, 1, 2, 1, 0, 307, "R3 R2 stalled add");
    // R5 R6 zero A, immediate B, stray go on port 0
    run_op(1, 0, 1, 40, 1, 77, 88, 9, 0, 0, 0, 0, 0, 1, 49, "R5 R6 imm+zero");
    // R7 wraparound
    run_op(1, 0, 0, 0, 0, 'hFFFF, 3, 1, 2, 0, 1, 0, 0, 0, 3, "R7 wrap add");
    // R5 R7 pass with zeroed A, inversion has no effect on pass
    run_op(0, 1, 1, 0, 0, 55, 66, 11, 0, 0, 0, 0, 0, 0, 0, "R5 R7 pass zero");
    // R11 third port stalled longest
    run_op(1, 0, 0, 0, 0, 1, 2, 300, 0, 0, 4, 0, 0, 0, 303, "R11 port2 add");
    // R10 reset in the middle of an operation
    @(negedge clk);
    issue_i = 1'b1; op_code_i = 2'd1; op_zero_a_i = 1'b0; op_imm_ok_i = 1'b0;
    op_inv_a_i = 1'b0;
    @(negedge clk);
    issue_i = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy_o && rd_rel_o == 0 && !wr_rel_o && data_o == 0, "R10 mid-op reset",
          int'(busy_o), 0);
    // recovery after reset, all grants coinciding with request rise
    run_op(1, 0, 0, 0, 0, 10, 20, 30, 0, 0, 0, 0, 0, 0, 60, "R4 R8 after reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule